// File: doc/BRIEF.md
# USB IN Packet Gathering Transmit Buffer

This block sits between a processor's byte-write port and a USB device engine's bulk IN endpoint. Software pushes characters one at a time into a 32-deep, 8-bit FIFO. Rather than handing bytes to the host one at a time, the buffer collects them into packets. It announces a packet to the USB engine once a full 32-byte packet has built up. It also announces one when some bytes are waiting and software has stopped writing for about 3.5 microseconds.

When the host issues an IN token, the USB engine reads the packet through a byte handshake: it reads `in_data_o`, then pulses `in_next_i` to step to the following byte. The engine then reports the outcome. `in_done_i` means the host acknowledged the packet, so the bytes that were stepped over leave the FIFO. `in_retry_i` means the host sent a NAK or the handshake failed, so the bytes stay in place and the next attempt starts again from the oldest byte.

The block also provides an occupancy output, a level-triggered watermark interrupt and a one-cycle overflow pulse for writes that arrive while the FIFO is full.

Top module: `usb_in_gather_txbuf`

## Requirements
- R1: After reset, `level_o`, `pkt_len_o`, `pkt_ready_o`, `wm_irq_o` and `ovf_irq_o` are all 0.
- R2: A write with `wr_valid_i` high while `level_o` is below 32 is accepted, and `level_o` rises by one on the following clock. `level_o` never exceeds 32.
- R3: Bytes reach `in_data_o` in the order they were written. Each `in_next_i` pulse presents the next byte on the following cycle.
- R4: A write while `level_o` equals 32 is dropped. The dropped byte never appears at `in_data_o` and `level_o` does not change. `ovf_irq_o` goes high for exactly one cycle, on the cycle after the write.
- R5: `pkt_ready_o` is high in the same cycle that `level_o` shows 32.
- R6: With 1 to 31 bytes held, `pkt_ready_o` rises after 175 clock cycles without an accepted write, which is 3.5 us at 50 MHz. The count starts at the edge that took the last write. Every accepted write restarts the count.
- R7: `pkt_len_o` equals the smaller of `level_o` and 32. `pkt_ready_o` is low whenever `level_o` is 0.
- R8: A one-cycle `in_done_i` removes exactly as many bytes as were stepped over with `in_next_i`, and `level_o` drops on the next clock. `in_data_o` then shows the oldest byte that was not sent.
- R9: A one-cycle `in_retry_i` (with `in_done_i` low) removes no bytes and returns `in_data_o` to the oldest byte.
- R10: `in_next_i` pulses beyond `pkt_len_o` bytes are ignored, so a following `in_done_i` removes at most `pkt_len_o` bytes.
- R11: `wm_irq_o` is high while `wm_level_i` is nonzero and `level_o` is at least `wm_level_i`. A `wm_level_i` of 0 holds `wm_irq_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Software byte write strobe |
| wr_data_i | input | 8 | Byte to enqueue |
| wm_level_i | input | 6 | Watermark threshold, 0 disables |
| pkt_ready_o | output | 1 | A packet is ready for the next IN token |
| pkt_len_o | output | 6 | Length of the packet being offered |
| in_data_o | output | 8 | Current packet byte |
| in_next_i | input | 1 | Step to the next packet byte |
| in_done_i | input | 1 | Host acknowledged; remove the sent bytes |
| in_retry_i | input | 1 | NAK or failed handshake; rewind to the oldest byte |
| level_o | output | 6 | FIFO occupancy, 0 to 32 |
| wm_irq_o | output | 1 | Watermark interrupt |
| ovf_irq_o | output | 1 | Overflow pulse |

## Verification
The idle flush is the hardest condition to reach from the ports. It needs a short packet, followed by a precisely counted quiet window, and a restart of that window partway through. The stimulus writes several bytes and pauses 100 cycles. It then writes again, so the first window is cut short, and checks that `pkt_ready_o` stays low one cycle before the 175-cycle mark and rises exactly at it. A rewind partway through a packet is also covered: two bytes are stepped over and then retried, and the first byte must reappear with nothing removed.

// File: rtl/usb_txg_pkg.sv
package usb_txg_pkg;

  typedef logic [7:0] txg_byte_t;

  // Idle window in clock cycles for a given clock rate and timeout in ns.
  function automatic int txg_idle_cycles(input int clk_hz, input int idle_ns);
    int cyc;
    cyc = (clk_hz / 1000000) * idle_ns / 1000;
    if (cyc < 1) cyc = 1;
    return cyc;
  endfunction

endpackage

// File: rtl/usb_txg_store.sv
module usb_txg_store
  import usb_txg_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LW    = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  txg_byte_t     push_data_i,
  input  logic          pop_i,
  input  logic [LW-1:0] pop_cnt_i,
  input  logic [LW-1:0] peek_off_i,
  output txg_byte_t     peek_data_o,
  output logic [LW-1:0] level_o
);

  localparam int AW = $clog2(DEPTH);

  txg_byte_t     mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [LW-1:0] level_q, level_d;
  logic [AW-1:0] peek_idx;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    level_d  = level_q;
    if (push_i) begin
      wr_ptr_d = wr_ptr_q + AW'(1);
      level_d  = level_d + LW'(1);
    end
    if (pop_i) begin
      rd_ptr_d = rd_ptr_q + pop_cnt_i[AW-1:0];
      level_d  = level_d - pop_cnt_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
    end
  end

  // Storage array: written under enable, not reset.
  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= push_data_i;
  end

  assign peek_idx    = rd_ptr_q + peek_off_i[AW-1:0];
  assign peek_data_o = mem_q[peek_idx];
  assign level_o     = level_q;

endmodule

// File: rtl/usb_txg_idle.sv
module usb_txg_idle #(
  parameter int IDLE_CYC = 175
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic expired_o
);

  localparam int CW = $clog2(IDLE_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          exp_q, exp_d;

  always_comb begin
    cnt_d = cnt_q;
    exp_d = exp_q;
    if (kick_i) begin
      cnt_d = '0;
      exp_d = 1'b0;
    end else if (!exp_q) begin
      if (cnt_q == CW'(IDLE_CYC - 1)) exp_d = 1'b1;
      else                            cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign expired_o = exp_q;

endmodule

// File: rtl/usb_txg_send.sv
module usb_txg_send #(
  parameter int LW      = 6,
  parameter int PKT_MAX = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LW-1:0] level_i,
  input  logic          expired_i,
  input  logic          next_i,
  input  logic          done_i,
  input  logic          retry_i,
  output logic [LW-1:0] off_o,
  output logic          pop_o,
  output logic [LW-1:0] pop_cnt_o,
  output logic          ready_o,
  output logic [LW-1:0] len_o
);

  logic [LW-1:0] off_q, off_d;
  logic [LW-1:0] len;

  assign len = (level_i > LW'(PKT_MAX)) ? LW'(PKT_MAX) : level_i;

  always_comb begin
    off_d = off_q;
    if (done_i || retry_i)           off_d = '0;
    else if (next_i && (off_q < len)) off_d = off_q + LW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) off_q <= '0;
    else         off_q <= off_d;
  end

  assign off_o     = off_q;
  assign pop_o     = done_i;
  assign pop_cnt_o = off_q;
  assign len_o     = len;
  assign ready_o   = (level_i != '0) && ((level_i >= LW'(PKT_MAX)) || expired_i);

endmodule

// File: rtl/usb_in_gather_txbuf.sv
module usb_in_gather_txbuf
  import usb_txg_pkg::*;
#(
  parameter int DEPTH       = 32,
  parameter int PKT_MAX     = 32,
  parameter int CLK_FREQ_HZ = 50_000_000,
  parameter int IDLE_NS     = 3500,
  localparam int LW         = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic [7:0]    wr_data_i,
  input  logic [LW-1:0] wm_level_i,
  output logic          pkt_ready_o,
  output logic [LW-1:0] pkt_len_o,
  output logic [7:0]    in_data_o,
  input  logic          in_next_i,
  input  logic          in_done_i,
  input  logic          in_retry_i,
  output logic [LW-1:0] level_o,
  output logic          wm_irq_o,
  output logic          ovf_irq_o
);

  localparam int IDLE_CYC = txg_idle_cycles(CLK_FREQ_HZ, IDLE_NS);

  logic [LW-1:0] level;
  logic [LW-1:0] off;
  logic [LW-1:0] pop_cnt;
  logic          pop;
  logic          full;
  logic          wr_acc;
  logic          expired;
  logic          ovf_q, ovf_d;

  assign full   = (level == LW'(DEPTH));
  assign wr_acc = wr_valid_i && !full;
  assign ovf_d  = wr_valid_i && full;

  usb_txg_store #(.DEPTH(DEPTH), .LW(LW)) i_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (wr_acc),
    .push_data_i (wr_data_i),
    .pop_i       (pop),
    .pop_cnt_i   (pop_cnt),
    .peek_off_i  (off),
    .peek_data_o (in_data_o),
    .level_o     (level)
  );

  usb_txg_idle #(.IDLE_CYC(IDLE_CYC)) i_idle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .kick_i    (wr_acc),
    .expired_o (expired)
  );

  usb_txg_send #(.LW(LW), .PKT_MAX(PKT_MAX)) i_send (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .level_i   (level),
    .expired_i (expired),
    .next_i    (in_next_i),
    .done_i    (in_done_i),
    .retry_i   (in_retry_i),
    .off_o     (off),
    .pop_o     (pop),
    .pop_cnt_o (pop_cnt),
    .ready_o   (pkt_ready_o),
    .len_o     (pkt_len_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else         ovf_q <= ovf_d;
  end

  assign ovf_irq_o = ovf_q;
  assign wm_irq_o  = (wm_level_i != '0) && (level >= wm_level_i);
  assign level_o   = level;

endmodule

// File: rtl/usb_txg_checker.sv
module usb_txg_checker #(
  parameter int DEPTH = 32,
  parameter int LW    = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_valid_i,
  input logic          in_done_i,
  input logic          in_retry_i,
  input logic          pkt_ready_o,
  input logic [LW-1:0] pkt_len_o,
  input logic [LW-1:0] level_o,
  input logic          ovf_irq_o
);

  assert_level_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LW'(DEPTH));

  assert_push_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && (level_o < LW'(DEPTH)) && !in_done_i |=> level_o == LW'($past(level_o) + LW'(1)));

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && (level_o == LW'(DEPTH)) |=> ovf_irq_o);

  assert_drop_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && (level_o == LW'(DEPTH)) && !in_done_i |=> level_o == LW'(DEPTH));

  assert_full_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == LW'(DEPTH)) |-> pkt_ready_o);

  assert_empty_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == '0) |-> !pkt_ready_o && (pkt_len_o == '0));

  assert_len_cap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_len_o <= level_o);

  assert_retry_keep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_retry_i && !in_done_i && !wr_valid_i |=> $stable(level_o));

endmodule

bind usb_in_gather_txbuf usb_txg_checker #(.DEPTH(DEPTH), .LW(LW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_valid_i  (wr_valid_i),
  .in_done_i   (in_done_i),
  .in_retry_i  (in_retry_i),
  .pkt_ready_o (pkt_ready_o),
  .pkt_len_o   (pkt_len_o),
  .level_o     (level_o),
  .ovf_irq_o   (ovf_irq_o)
);

// File: tb/test_usb_in_gather_txbuf.sv
`timescale 1ns/1ps
module test_usb_in_gather_txbuf;

  localparam int DEPTH = 32;
  localparam int IDLE  = 175;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       wr_valid_i;
  logic [7:0] wr_data_i;
  logic [5:0] wm_level_i;
  logic       pkt_ready_o;
  logic [5:0] pkt_len_o;
  logic [7:0] in_data_o;
  logic       in_next_i;
  logic       in_done_i;
  logic       in_retry_i;
  logic [5:0] level_o;
  logic       wm_irq_o;
  logic       ovf_irq_o;

  int tests = 0;
  int fails = 0;
  int mdl   = 0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  usb_in_gather_txbuf i_usb_in_gather_txbuf (
    .clk_i(clk), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i),
    .wm_level_i(wm_level_i), .pkt_ready_o(pkt_ready_o), .pkt_len_o(pkt_len_o),
    .in_data_o(in_data_o), .in_next_i(in_next_i), .in_done_i(in_done_i),
    .in_retry_i(in_retry_i), .level_o(level_o), .wm_irq_o(wm_irq_o), .ovf_irq_o(ovf_irq_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: one write, expected byte queued when the model has room.
  task automatic drive_wr(input logic [7:0] b);
    @(negedge clk);
    wr_valid_i = 1'b1;
    wr_data_i  = b;
    if (mdl < DEPTH) begin
      exp_q.push_back(b);
      mdl++;
    end
    @(negedge clk);
    wr_valid_i = 1'b0;
  endtask

  // Monitor: steps through n bytes comparing against the scoreboard, then
  // either commits (popping the scoreboard) or rewinds.
  task automatic mon_pkt(input int n, input int extra, input bit commit, input string tag);
    for (int i = 0; i < n; i++) begin
      chk(tag, in_data_o, exp_q[i]);
      in_next_i = 1'b1;
      @(negedge clk);
    end
    repeat (extra) @(negedge clk);
    in_next_i = 1'b0;
    if (commit) begin
      in_done_i = 1'b1;
      @(negedge clk);
      in_done_i = 1'b0;
      for (int i = 0; i < n; i++) void'(exp_q.pop_front());
      mdl -= n;
    end else begin
      in_retry_i = 1'b1;
      @(negedge clk);
      in_retry_i = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; wr_valid_i = 1'b0; wr_data_i = '0; wm_level_i = 6'd4;
    in_next_i = 1'b0; in_done_i = 1'b0; in_retry_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 level", level_o, 0);
    chk("R1 ready", pkt_ready_o, 0);
    chk("R1 len", pkt_len_o, 0);
    chk("R1 wm", wm_irq_o, 0);
    chk("R1 ovf", ovf_irq_o, 0);

    drive_wr(8'hA1); drive_wr(8'hA2); drive_wr(8'hA3);
    chk("R2 level after 3 writes", level_o, 3);
    chk("R11 wm below threshold", wm_irq_o, 0);
    chk("R6 not ready yet", pkt_ready_o, 0);
    repeat (100) @(negedge clk);
    drive_wr(8'hA4); drive_wr(8'hA5);
    chk("R11 wm at threshold", wm_irq_o, 1);
    repeat (IDLE - 1) @(negedge clk);
    chk("R6 ready before window", pkt_ready_o, 0);
    @(negedge clk);
    chk("R6 ready at window", pkt_ready_o, 1);
    chk("R7 len short", pkt_len_o, 5);

    mon_pkt(2, 0, 1'b0, "R3 order partial");
    chk("R9 level after retry", level_o, 5);
    chk("R9 data rewound", in_data_o, exp_q[0]);

    mon_pkt(5, 2, 1'b1, "R3 order full");
    chk("R10 level after extra steps", level_o, 0);
    chk("R7 empty not ready", pkt_ready_o, 0);

    drive_wr(8'hB1); drive_wr(8'hB2); drive_wr(8'hB3); drive_wr(8'hB4);
    repeat (IDLE) @(negedge clk);
    chk("R6 ready after idle", pkt_ready_o, 1);
    mon_pkt(2, 0, 1'b1, "R3 order B");
    chk("R8 level after partial commit", level_o, 2);
    chk("R8 oldest unsent byte", in_data_o, exp_q[0]);

    for (int i = 0; i < 29; i++) drive_wr(8'(8'h40 + i));
    chk("R2 level 31", level_o, 31);
    chk("R5 not ready at 31", pkt_ready_o, 0);
    drive_wr(8'h7F);
    chk("R5 ready at 32", pkt_ready_o, 1);
    chk("R7 len 32", pkt_len_o, 32);

    @(negedge clk);
    wr_valid_i = 1'b1; wr_data_i = 8'hEE;
    @(negedge clk);
    wr_valid_i = 1'b0;
    chk("R4 ovf pulse", ovf_irq_o, 1);
    chk("R4 level held", level_o, 32);
    @(negedge clk);
    chk("R4 ovf one cycle", ovf_irq_o, 0);

    mon_pkt(32, 0, 1'b1, "R4 dropped byte absent");
    chk("R8 drained", level_o, 0);

    drive_wr(8'h55);
    wm_level_i = 6'd0; #1;
    chk("R11 threshold zero", wm_irq_o, 0);
    wm_level_i = 6'd1; #1;
    chk("R11 threshold one", wm_irq_o, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule